// File: doc/BRIEF.md
# PCM Master Bit-Clock and Frame-Sync Generator

This block is the clock master of a PCM audio port. It divides an internal reference down to a serial bit clock, counts bit clocks into frames and drives a frame sync pulse. A one-cycle strobe marks every rising and every falling bit-clock edge, so the serial data path can shift without detecting edges itself. The analog references and the data path are outside this block.

Division uses a phase accumulator. On every reference tick the accumulator adds a step and subtracts a limit whenever the sum reaches it. Each wrap toggles the bit clock.

The block has two rate modes:
- **Low-rate mode** is clocked by a 4 MHz tick. It uses one of three fixed steps over a modulus of 125.
- **High-rate mode** advances on every cycle of the 48 MHz core clock. Its step and limit are programmable.

Frame length, sync shape (long or short), long-sync width and a codec power-down mode are all configurable. A new setting is adopted only at a frame boundary.

Top module: `pcmclk_gen`

## Requirements
- R1: While `rst` is high (sampled on `clk`), `bclk`, `fsync`, `rise_stb` and `fall_stb` are all 0.
- R2: After reset the active setting is low-rate mode at 256 kHz, long sync, 8 bits wide, 32 bit clocks per frame, whatever the configuration inputs hold. The first rising bit-clock edge therefore comes on the 8th `ref4_tick` pulse. That edge is the first frame boundary.
- R3: In low-rate mode the accumulator advances only on `ref4_tick` pulses and has a modulus of 125. `cfg_lo_sel` selects the step: 0 gives 8 (128 kHz), 2 gives 32 (512 kHz), and 1 or 3 gives 16 (256 kHz). With a 4 MHz tick, a 512 kHz clock over a 64-bit frame and a 128 kHz clock over a 16-bit frame each give frames of exactly 500 ticks (8 kHz).
- R4: In high-rate mode the accumulator adds `cfg_rate` on every `clk` cycle and wraps at `cfg_limit`. With step 1 and limit 3, the bit clock has a 6-cycle period and a 3-cycle half period. With step 8 and limit 125 over a 32-bit frame, a frame is 1000 cycles long.
- R5: A frame spans `cfg_frame_len` rising bit-clock edges.
- R6: A long sync rises with the first rising edge of a frame. It stays high for 16 bit clocks when high-rate mode and `cfg_long_wide` are both set, and for 8 bit clocks otherwise. In low-rate mode `cfg_long_wide` has no effect.
- R7: A short sync (`cfg_short`=1) is high for exactly one bit clock, the last one of the frame. Its falling edge coincides with the rising edge that starts the next frame.
- R8: With `cfg_pdown` active, `fsync` stays 0 while `bclk` keeps toggling at its programmed rate. Clearing `cfg_pdown` brings the sync back.
- R9: Configuration inputs are adopted only at the rising edge that starts a frame, and the accumulator restarts from zero there. A frame that is in progress keeps its old timing.
- R10: `rise_stb` is high for one cycle in each cycle in which `bclk` has just gone to 1. `fall_stb` does the same when `bclk` has just gone to 0. `bclk` changes in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz core/reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ref4_tick | input | 1 | One-cycle pulse at the 4 MHz low-rate reference rate |
| cfg_fast | input | 1 | 1 selects high-rate mode |
| cfg_lo_sel | input | 2 | Low-rate bit-clock choice |
| cfg_rate | input | 12 | High-rate accumulator step |
| cfg_limit | input | 12 | High-rate accumulator modulus |
| cfg_frame_len | input | 9 | Bit clocks per frame |
| cfg_short | input | 1 | 1 selects short sync |
| cfg_long_wide | input | 1 | 16-bit-wide long sync in high-rate mode |
| cfg_pdown | input | 1 | Hold sync low (codec power-down) |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| rise_stb | output | 1 | Strobe for a bit-clock rising edge |
| fall_stb | output | 1 | Strobe for a bit-clock falling edge |

## Verification
The hardest situations to reach from the ports are a configuration change landing in the middle of a frame and the window before the first frame boundary, where only the reset setting can act.

The bench holds non-default inputs through reset. It then times the first rising edge in reference ticks, which exposes the reset setting before the first load replaces it.

For the mid-frame case, the bench waits a fixed number of cycles past a sync rising edge before changing the limit. It then checks that the running frame keeps its old length and that the following frame takes the new one.

// File: rtl/pcmclk_pkg.sv
package pcmclk_pkg;

    parameter int ACC_W = 12;
    parameter int POS_W = 9;

    localparam int LO_MODULUS   = 125;
    localparam int SYNC_NARROW  = 8;
    localparam int SYNC_WIDE    = 16;
    localparam int RESET_FRAME  = 32;

    typedef struct packed {
        logic              fast;
        logic [1:0]        lo_sel;
        logic [ACC_W-1:0]  rate;
        logic [ACC_W-1:0]  limit;
        logic [POS_W-1:0]  frame_len;
        logic              short_sync;
        logic              long_wide;
        logic              pdown;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{
        fast:       1'b0,
        lo_sel:     2'd1,
        rate:       '0,
        limit:      '0,
        frame_len:  POS_W'(RESET_FRAME),
        short_sync: 1'b0,
        long_wide:  1'b0,
        pdown:      1'b0
    };

    function automatic logic [ACC_W-1:0] lo_step(input logic [1:0] sel);
        case (sel)
            2'd0:    return ACC_W'(8);
            2'd2:    return ACC_W'(32);
            default: return ACC_W'(16);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] long_width(input clk_cfg_t c);
        return (c.fast && c.long_wide) ? POS_W'(SYNC_WIDE) : POS_W'(SYNC_NARROW);
    endfunction

endpackage

// File: rtl/pcmclk_accum.sv
module pcmclk_accum #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    input  logic [W-1:0] step,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, step};
        wrap = tick && (sum >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (clear)
            acc_q <= '0;
        else if (tick)
            acc_q <= wrap ? W'(sum - {1'b0, limit}) : sum[W-1:0];
    end

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(acc_q));

endmodule

// File: rtl/pcmclk_frame.sv
module pcmclk_frame #(
    parameter int PW      = 9,
    parameter int RST_POS = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic [PW-1:0] len_act,
    input  logic [PW-1:0] len_nxt,
    input  logic [PW-1:0] width_nxt,
    input  logic          short_nxt,
    input  logic          pdown_nxt,
    output logic          boundary,
    output logic          fsync
);
    logic [PW-1:0] pos_q;
    logic [PW-1:0] pos_next;
    logic          sync_next;

    always_comb begin
        boundary = advance && (pos_q >= len_act - PW'(1));
        pos_next = boundary ? '0 : pos_q + PW'(1);
        if (pdown_nxt)
            sync_next = 1'b0;
        else if (short_nxt)
            sync_next = (pos_next == len_nxt - PW'(1));
        else
            sync_next = (pos_next < width_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= PW'(RST_POS);
            fsync <= 1'b0;
        end else if (advance) begin
            pos_q <= pos_next;
            fsync <= sync_next;
        end
    end

    // R5
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        (len_act != '0) |-> (pos_q < len_act));

    // R7
    sync_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fsync) |-> $past(advance));

endmodule

// File: rtl/pcmclk_gen.sv
module pcmclk_gen
    import pcmclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref4_tick,
    input  logic             cfg_fast,
    input  logic [1:0]       cfg_lo_sel,
    input  logic [ACC_W-1:0] cfg_rate,
    input  logic [ACC_W-1:0] cfg_limit,
    input  logic [POS_W-1:0] cfg_frame_len,
    input  logic             cfg_short,
    input  logic             cfg_long_wide,
    input  logic             cfg_pdown,
    output logic             bclk,
    output logic             fsync,
    output logic             rise_stb,
    output logic             fall_stb
);
    clk_cfg_t         live_cfg, act_q, nxt_cfg;
    logic             tick, wrap, rise_now, boundary;
    logic [ACC_W-1:0] step_sel, limit_sel;

    always_comb begin
        live_cfg = '{fast: cfg_fast, lo_sel: cfg_lo_sel, rate: cfg_rate,
                     limit: cfg_limit, frame_len: cfg_frame_len,
                     short_sync: cfg_short, long_wide: cfg_long_wide,
                     pdown: cfg_pdown};
        tick      = act_q.fast ? 1'b1 : ref4_tick;
        step_sel  = act_q.fast ? act_q.rate  : lo_step(act_q.lo_sel);
        limit_sel = act_q.fast ? act_q.limit : ACC_W'(LO_MODULUS);
        rise_now  = wrap && !bclk;
        nxt_cfg   = boundary ? live_cfg : act_q;
    end

    pcmclk_accum #(.W(ACC_W)) u_accum (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .clear (boundary),
        .step  (step_sel),
        .limit (limit_sel),
        .wrap  (wrap)
    );

    pcmclk_frame #(.PW(POS_W), .RST_POS(RESET_FRAME - 1)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .advance   (rise_now),
        .len_act   (act_q.frame_len),
        .len_nxt   (nxt_cfg.frame_len),
        .width_nxt (long_width(nxt_cfg)),
        .short_nxt (nxt_cfg.short_sync),
        .pdown_nxt (nxt_cfg.pdown),
        .boundary  (boundary),
        .fsync     (fsync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= CFG_RESET;
            bclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            if (boundary)
                act_q <= live_cfg;
            if (wrap)
                bclk <= !bclk;
            rise_stb <= rise_now;
            fall_stb <= wrap && bclk;
        end
    end

    // R10
    rise_level_chk: assert property (@(posedge clk) disable iff (rst)
        rise_stb |-> bclk);

    // R10
    fall_level_chk: assert property (@(posedge clk) disable iff (rst)
        fall_stb |-> !bclk);

    // R10
    edge_has_stb_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bclk) |-> (rise_stb || fall_stb));

    // R8
    pdown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        act_q.pdown |-> !fsync);

    // R3
    lo_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!act_q.fast && !ref4_tick) |=> $stable(bclk));

endmodule

// File: tb/pcmclk_gen_tb.sv
module pcmclk_gen_tb;
    import pcmclk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ref4_tick = 1'b0;
    logic             cfg_fast = 1'b0;
    logic [1:0]       cfg_lo_sel = 2'd2;
    logic [ACC_W-1:0] cfg_rate = '0;
    logic [ACC_W-1:0] cfg_limit = '0;
    logic [POS_W-1:0] cfg_frame_len = POS_W'(64);
    logic             cfg_short = 1'b0;
    logic             cfg_long_wide = 1'b1;
    logic             cfg_pdown = 1'b0;
    logic             bclk, fsync, rise_stb, fall_stb;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcmclk_gen u_dut (
        .clk(clk), .rst(rst), .ref4_tick(ref4_tick), .cfg_fast(cfg_fast),
        .cfg_lo_sel(cfg_lo_sel), .cfg_rate(cfg_rate), .cfg_limit(cfg_limit),
        .cfg_frame_len(cfg_frame_len), .cfg_short(cfg_short),
        .cfg_long_wide(cfg_long_wide), .cfg_pdown(cfg_pdown),
        .bclk(bclk), .fsync(fsync), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    int errors = 0;
    int checks = 0;

    int cyc, ticks, rises, last_rise_cyc, rise_gap, fall_off;
    int sync_rises, last_sr_cyc, last_sr_tick, frame_cyc, frame_tick;
    int wcnt, last_width, sync_hi_cyc, first_rise_tick, bad_stb;
    int divc = 0;
    logic sync_prev;

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; ticks = 0; rises = 0; last_rise_cyc = 0; rise_gap = 0;
            fall_off = 0; sync_rises = 0; last_sr_cyc = 0; last_sr_tick = 0;
            frame_cyc = 0; frame_tick = 0; wcnt = 0; last_width = 0;
            sync_hi_cyc = 0; first_rise_tick = -1; bad_stb = 0; sync_prev = 1'b0;
        end else begin
            cyc++;
            if (ref4_tick) ticks++;
            if (fsync && !sync_prev) begin
                sync_rises++;
                frame_cyc = cyc - last_sr_cyc;
                frame_tick = ticks - last_sr_tick;
                last_sr_cyc = cyc;
                last_sr_tick = ticks;
                wcnt = 0;
            end
            if (!fsync && sync_prev) last_width = wcnt;
            if (rise_stb) begin
                rises++;
                if (first_rise_tick < 0) first_rise_tick = ticks;
                rise_gap = cyc - last_rise_cyc;
                last_rise_cyc = cyc;
                if (fsync) wcnt++;
                if (!bclk) bad_stb++;
            end
            if (fall_stb) begin
                fall_off = cyc - last_rise_cyc;
                if (bclk) bad_stb++;
            end
            if (fsync) sync_hi_cyc++;
            sync_prev = fsync;
        end
        divc = (divc == 11) ? 0 : divc + 1;
        ref4_tick <= (divc == 0);
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_sync(input int n, input int limit);
        int start = sync_rises;
        int k = 0;
        while (sync_rises < start + n && k < limit) begin
            @(posedge clk); #1;
            k++;
        end
        check_eq("R5", "sync edges seen before timeout", sync_rises - start, n);
    endtask

    task automatic set_fast(input int rate, input int limit, input int flen,
                            input bit shrt, input bit wide, input bit pd);
        @(posedge clk); #1;
        cfg_fast = 1'b1;
        cfg_rate = ACC_W'(rate);
        cfg_limit = ACC_W'(limit);
        cfg_frame_len = POS_W'(flen);
        cfg_short = shrt;
        cfg_long_wide = wide;
        cfg_pdown = pd;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check_eq("R1", "bclk in reset", int'(bclk), 0);
        check_eq("R1", "fsync in reset", int'(fsync), 0);
        check_eq("R1", "rise_stb in reset", int'(rise_stb), 0);
        check_eq("R1", "fall_stb in reset", int'(fall_stb), 0);
        rst = 1'b0;
    endtask

    task automatic t_default_low;
        int k = 0;
        while (rises < 1 && k < 2000) begin
            @(posedge clk); #1;
            k++;
        end
        check_eq("R2", "ref ticks to first rising edge", first_rise_tick, 8);
        check_eq("R2", "first edge opens a frame", sync_rises, 1);
        wait_sync(2, 20000);
        check_eq("R3", "512k/64 frame in ref ticks", frame_tick, 500);
        check_eq("R6", "low-rate long sync width", last_width, 8);
    endtask

    task automatic t_low128;
        @(posedge clk); #1;
        cfg_lo_sel = 2'd0;
        cfg_frame_len = POS_W'(16);
        wait_sync(2, 20000);
        check_eq("R3", "128k/16 frame in ref ticks", frame_tick, 500);
    endtask

    task automatic t_fast_long8;
        set_fast(1, 3, 24, 1'b0, 1'b0, 1'b0);
        wait_sync(2, 20000);
        check_eq("R5", "frame cycles step1/limit3/24", frame_cyc, 144);
        check_eq("R4", "bit clock period", rise_gap, 6);
        check_eq("R10", "fall strobe after rise", fall_off, 3);
        check_eq("R6", "narrow long sync width", last_width, 8);
    endtask

    task automatic t_fast_long16;
        set_fast(1, 3, 24, 1'b0, 1'b1, 1'b0);
        wait_sync(2, 2000);
        check_eq("R6", "wide long sync width", last_width, 16);
        check_eq("R5", "frame cycles wide sync", frame_cyc, 144);
    endtask

    task automatic t_fast_1536;
        set_fast(8, 125, 32, 1'b0, 1'b0, 1'b0);
        wait_sync(2, 5000);
        check_eq("R4", "1536k/32 frame cycles", frame_cyc, 1000);
    endtask

    task automatic t_short;
        set_fast(1, 3, 24, 1'b1, 1'b0, 1'b0);
        wait_sync(2, 5000);
        check_eq("R7", "short sync width", last_width, 1);
        check_eq("R7", "short sync frame cycles", frame_cyc, 144);
    endtask

    task automatic t_midframe;
        set_fast(1, 3, 24, 1'b0, 1'b0, 1'b0);
        wait_sync(2, 2000);
        repeat (50) @(posedge clk);
        #1;
        cfg_limit = ACC_W'(5);
        wait_sync(1, 2000);
        check_eq("R9", "running frame keeps old length", frame_cyc, 144);
        wait_sync(1, 2000);
        check_eq("R9", "next frame takes new length", frame_cyc, 240);
    endtask

    task automatic t_pdown;
        int hi0, r0;
        set_fast(1, 3, 24, 1'b0, 1'b0, 1'b1);
        repeat (400) @(posedge clk);
        #1;
        hi0 = sync_hi_cyc;
        r0 = rises;
        repeat (300) @(posedge clk);
        #1;
        check_eq("R8", "sync high cycles in power-down", sync_hi_cyc - hi0, 0);
        check_eq("R8", "bit clock keeps running", int'((rises - r0) >= 49 && (rises - r0) <= 51), 1);
        cfg_pdown = 1'b0;
        wait_sync(1, 400);
    endtask

    initial begin
        t_reset;
        t_default_low;
        t_low128;
        t_fast_long8;
        t_fast_long16;
        t_fast_1536;
        t_short;
        t_midframe;
        t_pdown;
        check_eq("R10", "strobe/level mismatches", bad_stb, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule